// File: doc/BRIEF.md
# Backplane Interrupt Acknowledge Sequencer

This block serves the seven prioritised interrupt request lines of a shared backplane. Software chooses which request levels the block responds to. When an enabled level is pending and not yet flagged, the block asks for the backplane and waits for a grant. It then runs an acknowledge cycle that names the level with a 3-bit code. The word that the interrupting board returns is stored in that level's own status/ID register. The level's status bit is then set, and this raises a host interrupt.

Four other event sources share the same status register: a mailbox event, power-fail, bus error and system-fail. A fifth flag records an acknowledge cycle that ended in a bus error. A routing bit for each source sends its status bit to either the normal host interrupt output or the error host output. Both outputs are level-sensitive. Software clears status bits by writing ones to them.

The register map uses a 4-bit address:

| Address | Register |
|---|---|
| 0 | Level enable. Bit n-1 enables level n. |
| 1 | Routing. Uses the status bit layout. A 1 selects the error output. |
| 2 | Status. Write 1 to clear. |
| 8 to 14 | ID words for levels 1 to 7. Read-only. |

The status bit layout is:

| Bits | Source |
|---|---|
| 0 to 6 | Levels 1 to 7 |
| 7 | Mailbox |
| 8 | Power-fail |
| 9 | Bus error |
| 10 | System-fail |
| 11 | Acknowledge fault |

Top module: `irq_ack_handler`

## Requirements
- R1: After reset, bus_req_o, ack_active_o, host_int_o and host_err_o are low, and the enable, routing, status and ID registers all read zero.
- R2: A level that is enabled, has its request input high and has its status bit clear makes bus_req_o rise in the next cycle. ack_active_o rises only after bus_grant_i is seen. bus_req_o stays high until the cycle in which ack_done_i ends the acknowledge cycle.
- R3: When several levels qualify, the highest level is acknowledged first. ack_level_o carries the level number (1 to 7) and stays steady for the whole acknowledge cycle.
- R4: A request on a level whose enable bit (address 0, bit level-1) is clear causes no bus request and sets no status bit.
- R5: A cycle that completes without a bus error stores ack_id_i in the ID register at address 7+level. It also sets status bit level-1.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A level whose status bit is set is not requested or acknowledged again.
- R7: A cycle that completes with ack_berr_i high sets status bit 11 and leaves the level's status bit and ID register unchanged.
- R8: Status bit 7 (mailbox), bit 8 (power-fail), bit 9 (bus error) and bit 10 (system-fail) are set in every cycle in which their input is high. While the input is high, setting wins over a clear written in the same cycle.
- R9: host_int_o is high while any set status bit has routing bit 0. host_err_o is high while any set status bit has routing bit 1. A change to the routing register moves an asserted source between the outputs at once.
- R10: The enable register at address 0 and the routing register at address 1 read back the last values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 7 | Request lines; bit n-1 is level n, active high |
| mbox_evt_i | input | 1 | Mailbox event |
| pwr_fail_i | input | 1 | Power-fail event |
| bus_err_i | input | 1 | Backplane bus error event |
| sys_fail_i | input | 1 | System-fail event |
| bus_req_o | output | 1 | Backplane request |
| bus_grant_i | input | 1 | Backplane grant |
| ack_active_o | output | 1 | Acknowledge cycle in progress |
| ack_level_o | output | 3 | Level number being acknowledged |
| ack_done_i | input | 1 | Acknowledge cycle complete |
| ack_berr_i | input | 1 | Completion ended in a bus error |
| ack_id_i | input | 8 | Status/ID word returned by the interrupter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| host_int_o | output | 1 | Normal host interrupt |
| host_err_o | output | 1 | Error host interrupt |

## Verification
The assertions check the following on every cycle:
- The bus is held for the whole acknowledge cycle and released only after a completion.
- The level code is legal and steady.
- A flagged level is never acknowledged again.
- A completion updates either the level's flag or the fault flag.
- Neither host output is asserted while the status register is empty.

Only the bench's scenarios can show the rest: that levels are served highest first, that disabled levels stay silent, that the right ID word lands at the right address, that a faulted cycle leaves the ID untouched, and that routing steers each source to the chosen output.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_ACK
    } seq_state_e;

    // Width of the level code driven during an acknowledge cycle
    localparam int LVL_W = 3;

    // Non-level sources, placed above the level bits in the status word
    localparam int XS_MBOX = 0;
    localparam int XS_PWRF = 1;
    localparam int XS_BERR = 2;
    localparam int XS_SYSF = 3;
    localparam int XS_AFLT = 4;
    localparam int N_EXTRA = 5;
    localparam int N_EVT   = N_EXTRA - 1;  // externally driven events

    // Register addresses
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] RA_ENABLE  = 4'd0;
    localparam logic [ADDR_W-1:0] RA_ROUTE   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_STATUS  = 4'd2;
    localparam logic [ADDR_W-1:0] RA_ID_BASE = 4'd8;

endpackage

// File: rtl/irqh_pick.sv
// Fixed-priority picker: the highest set index wins; the code is index+1.
module irqh_pick
    import irqh_pkg::*;
#(
    parameter int N = 7
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [LVL_W-1:0] code_o
);

    logic [N:0]   above;    // above[i]: some request at index >= i
    logic [N-1:0] win;      // one-hot winner

    assign above[N] = 1'b0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_chain
        assign above[i] = above[i+1] | req_i[i];
        assign win[i]   = req_i[i] & ~above[i+1];
    end

    assign any_o = above[0];

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) begin
                code_o = LVL_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/irqh_seq.sv
// Acknowledge sequencer: request bus, wait grant, run acknowledge cycle.
module irqh_seq
    import irqh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_any_i,
    input  logic [LVL_W-1:0] pend_code_i,
    input  logic             bus_grant_i,
    input  logic             ack_done_i,
    input  logic             ack_berr_i,
    output logic             bus_req_o,
    output logic             ack_active_o,
    output logic [LVL_W-1:0] ack_level_o,
    output logic             fin_ok_o,
    output logic             fin_err_o
);

    typedef struct packed {
        seq_state_e       st;
        logic [LVL_W-1:0] lvl;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        fin_ok_o  = 1'b0;
        fin_err_o = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (pend_any_i) begin
                    seq_d.st  = SEQ_REQ;
                    seq_d.lvl = pend_code_i;
                end
            end
            SEQ_REQ: begin
                if (bus_grant_i) begin
                    seq_d.st = SEQ_ACK;
                end
            end
            SEQ_ACK: begin
                if (ack_done_i) begin
                    fin_ok_o  = ~ack_berr_i;
                    fin_err_o = ack_berr_i;
                    seq_d.st  = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, lvl: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_req_o    = (seq_q.st != SEQ_IDLE);
    assign ack_active_o = (seq_q.st == SEQ_ACK);
    assign ack_level_o  = seq_q.lvl;

endmodule

// File: rtl/irqh_regs.sv
// Enable, routing, status and per-level ID storage with read mux.
module irqh_regs
    import irqh_pkg::*;
#(
    parameter int NLVL   = 7,
    parameter int ID_W   = 8,
    parameter int DATA_W = 16,
    localparam int NSRC  = NLVL + N_EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              fin_ok_i,
    input  logic              fin_err_i,
    input  logic [LVL_W-1:0]  fin_lvl_i,
    input  logic [ID_W-1:0]   ack_id_i,
    output logic [NLVL-1:0]   en_o,
    output logic [NSRC-1:0]   route_o,
    output logic [NSRC-1:0]   status_o
);

    typedef struct packed {
        logic [NLVL-1:0]            en;
        logic [NSRC-1:0]            route;
        logic [NSRC-1:0]            status;
        logic [NLVL-1:0][ID_W-1:0]  ids;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (addr_i)
                RA_ENABLE: r_d.en     = wdata_i[NLVL-1:0];
                RA_ROUTE:  r_d.route  = wdata_i[NSRC-1:0];
                RA_STATUS: r_d.status = r_q.status & ~wdata_i[NSRC-1:0];
                default: ;
            endcase
        end
        // event sources set their bit; setting wins over a clear
        for (int k = 0; k < N_EVT; k++) begin
            if (evt_i[k]) begin
                r_d.status[NLVL+k] = 1'b1;
            end
        end
        // completed acknowledge: capture ID, flag level
        for (int l = 0; l < NLVL; l++) begin
            if (fin_ok_i && (fin_lvl_i == LVL_W'(l + 1))) begin
                r_d.ids[l]    = ack_id_i;
                r_d.status[l] = 1'b1;
            end
        end
        if (fin_err_i) begin
            r_d.status[NLVL+XS_AFLT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_ENABLE: rdata_o[NLVL-1:0] = r_q.en;
            RA_ROUTE:  rdata_o[NSRC-1:0] = r_q.route;
            RA_STATUS: rdata_o[NSRC-1:0] = r_q.status;
            default: begin
                for (int l = 0; l < NLVL; l++) begin
                    if (addr_i == RA_ID_BASE + ADDR_W'(l)) begin
                        rdata_o[ID_W-1:0] = r_q.ids[l];
                    end
                end
            end
        endcase
    end

    assign en_o     = r_q.en;
    assign route_o  = r_q.route;
    assign status_o = r_q.status;

endmodule

// File: rtl/irq_ack_handler.sv
// Top: interrupt handler with hardware acknowledge sequencing.
module irq_ack_handler
    import irqh_pkg::*;
#(
    parameter int NLVL   = 7,
    parameter int ID_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLVL-1:0]   irq_i,
    input  logic              mbox_evt_i,
    input  logic              pwr_fail_i,
    input  logic              bus_err_i,
    input  logic              sys_fail_i,
    output logic              bus_req_o,
    input  logic              bus_grant_i,
    output logic              ack_active_o,
    output logic [LVL_W-1:0]  ack_level_o,
    input  logic              ack_done_i,
    input  logic              ack_berr_i,
    input  logic [ID_W-1:0]   ack_id_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              host_int_o,
    output logic              host_err_o
);

    localparam int NSRC = NLVL + N_EXTRA;

    logic [NLVL-1:0]  en_w;
    logic [NSRC-1:0]  route_w;
    logic [NSRC-1:0]  status_w;
    logic [NLVL-1:0]  pend_w;
    logic             pend_any_w;
    logic [LVL_W-1:0] pend_code_w;
    logic             fin_ok_w;
    logic             fin_err_w;
    logic [N_EVT-1:0] evt_w;

    // qualified requests: enabled and not already flagged
    assign pend_w = irq_i & en_w & ~status_w[NLVL-1:0];

    assign evt_w = {sys_fail_i, bus_err_i, pwr_fail_i, mbox_evt_i};

    irqh_pick #(.N(NLVL)) u_pick (
        .req_i  (pend_w),
        .any_o  (pend_any_w),
        .code_o (pend_code_w)
    );

    irqh_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_any_i   (pend_any_w),
        .pend_code_i  (pend_code_w),
        .bus_grant_i  (bus_grant_i),
        .ack_done_i   (ack_done_i),
        .ack_berr_i   (ack_berr_i),
        .bus_req_o    (bus_req_o),
        .ack_active_o (ack_active_o),
        .ack_level_o  (ack_level_o),
        .fin_ok_o     (fin_ok_w),
        .fin_err_o    (fin_err_w)
    );

    irqh_regs #(.NLVL(NLVL), .ID_W(ID_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .evt_i     (evt_w),
        .fin_ok_i  (fin_ok_w),
        .fin_err_i (fin_err_w),
        .fin_lvl_i (ack_level_o),
        .ack_id_i  (ack_id_i),
        .en_o      (en_w),
        .route_o   (route_w),
        .status_o  (status_w)
    );

    assign host_int_o = |(status_w & ~route_w);
    assign host_err_o = |(status_w & route_w);

endmodule

// File: rtl/irqh_chk.sv
// Protocol checker bound into the top module.
module irqh_chk
    import irqh_pkg::*;
#(
    parameter int NLVL = 7,
    localparam int NSRC = NLVL + N_EXTRA
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req_o,
    input logic             ack_active_o,
    input logic [LVL_W-1:0] ack_level_o,
    input logic             ack_done_i,
    input logic             ack_berr_i,
    input logic [NSRC-1:0]  status,
    input logic             host_int_o,
    input logic             host_err_o
);

    logic [NLVL-1:0] lvl_hot;
    always_comb begin
        lvl_hot = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (ack_level_o == LVL_W'(l + 1)) begin
                lvl_hot[l] = 1'b1;
            end
        end
    end

    a_r2_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active_o |-> bus_req_o);

    a_r2_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> $past(ack_done_i));

    a_r3_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active_o |-> (ack_level_o != '0 && int'(ack_level_o) <= NLVL));

    a_r3_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active_o && $past(ack_active_o)) |-> $stable(ack_level_o));

    a_r6_no_reack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active_o |-> !(|(lvl_hot & status[NLVL-1:0])));

    a_r5_flag_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active_o && ack_done_i && !ack_berr_i) |=> |(lvl_hot & status[NLVL-1:0]));

    a_r7_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active_o && ack_done_i && ack_berr_i) |=> status[NLVL+XS_AFLT]);

    a_r9_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!host_int_o && !host_err_o));

endmodule

bind irq_ack_handler irqh_chk #(.NLVL(NLVL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_o    (bus_req_o),
    .ack_active_o (ack_active_o),
    .ack_level_o  (ack_level_o),
    .ack_done_i   (ack_done_i),
    .ack_berr_i   (ack_berr_i),
    .status       (status_w),
    .host_int_o   (host_int_o),
    .host_err_o   (host_err_o)
);

// File: tb/irq_ack_handler_bench.sv
module irq_ack_handler_bench;
    import irqh_pkg::*;

    localparam int NLVL = 7;
    localparam int ID_W = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NLVL-1:0]   irq_i = '0;
    logic              mbox_evt_i = 1'b0, pwr_fail_i = 1'b0, bus_err_i = 1'b0, sys_fail_i = 1'b0;
    logic              bus_req_o, bus_grant_i = 1'b0;
    logic              ack_active_o;
    logic [LVL_W-1:0]  ack_level_o;
    logic              ack_done_i = 1'b0, ack_berr_i = 1'b0;
    logic [ID_W-1:0]   ack_id_i = '0;
    logic              reg_we_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              host_int_o, host_err_o;

    always #10 clk = ~clk;  // 50 MHz

    irq_ack_handler u_irq_ack_handler (.*);

    typedef struct {
        int         lvl;
        logic [7:0] id;
        bit         berr;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic chk_eq(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic expect_ack(int lvl, logic [7:0] id, bit berr);
        exp_t e;
        e.lvl = lvl; e.id = id; e.berr = berr;
        q.push_back(e);
    endtask

    task automatic drain();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((q.size() != 0 || bus_req_o) && n < 300);
        chk_eq("R2 all expected acknowledges served", q.size(), 0);
    endtask

    // Monitor / responder: grants the bus and answers acknowledge cycles
    initial begin
        bit   done_hi;
        exp_t e;
        done_hi = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bus_grant_i = bus_req_o;
                if (done_hi) begin
                    ack_done_i = 1'b0; ack_berr_i = 1'b0; done_hi = 0;
                end else if (ack_active_o) begin
                    if (q.size() == 0) begin
                        chk_eq("R4/R6 unexpected acknowledge level", ack_level_o, 0);
                        ack_id_i = 8'h00;
                    end else begin
                        e = q.pop_front();
                        chk_eq("R3 acknowledge order and level code", ack_level_o, e.lvl);
                        ack_id_i   = e.id;
                        ack_berr_i = e.berr;
                        if (e.berr) irq_i[e.lvl-1] = 1'b0;
                    end
                    ack_done_i = 1'b1;
                    done_hi = 1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_eq("R1 bus_req_o in reset", bus_req_o, 0);
        chk_eq("R1 ack_active_o in reset", ack_active_o, 0);
        chk_eq("R1 host_int_o in reset", host_int_o, 0);
        chk_eq("R1 host_err_o in reset", host_err_o, 0);
        rst_n = 1'b1;
        rd(RA_ENABLE, v);  chk_eq("R1 enable after reset", v, 0);
        rd(RA_ROUTE, v);   chk_eq("R1 route after reset", v, 0);
        rd(RA_STATUS, v);  chk_eq("R1 status after reset", v, 0);
        rd(4'd10, v);      chk_eq("R1 ID level 3 after reset", v, 0);

        wr(RA_ENABLE, 16'h007F);
        wr(RA_ROUTE, 16'h0800);
        rd(RA_ENABLE, v);  chk_eq("R10 enable readback", v, 16'h007F);
        rd(RA_ROUTE, v);   chk_eq("R10 route readback", v, 16'h0800);

        // R2 / R5 single level
        expect_ack(3, 8'hA3, 0);
        @(negedge clk); irq_i[2] = 1'b1;
        @(negedge clk);
        chk_eq("R2 request one cycle after pending", bus_req_o, 1);
        chk_eq("R2 no acknowledge before grant", ack_active_o, 0);
        drain();
        rd(RA_STATUS, v);  chk_eq("R5 level 3 flagged", v, 16'h0004);
        rd(4'd10, v);      chk_eq("R5 ID level 3 captured", v, 16'h00A3);
        chk_eq("R9 normal output for level 3", host_int_o, 1);
        chk_eq("R9 error output quiet", host_err_o, 0);

        // R6 no re-acknowledge while flagged; W1C
        repeat (20) @(negedge clk);
        chk_eq("R6 no request while flagged", bus_req_o, 0);
        irq_i[2] = 1'b0;
        wr(RA_STATUS, 16'h0000);
        rd(RA_STATUS, v);  chk_eq("R6 writing zero keeps bit", v, 16'h0004);
        wr(RA_STATUS, 16'h0004);
        rd(RA_STATUS, v);  chk_eq("R6 write one clears", v, 16'h0000);
        chk_eq("R9 normal output drops when clear", host_int_o, 0);

        // R3 priority
        expect_ack(7, 8'h77, 0);
        expect_ack(5, 8'h55, 0);
        expect_ack(2, 8'h22, 0);
        @(negedge clk); irq_i = 7'b1010010;
        drain();
        rd(RA_STATUS, v);  chk_eq("R3 three levels flagged", v, 16'h0052);
        rd(4'd14, v);      chk_eq("R5 ID level 7", v, 16'h0077);
        rd(4'd12, v);      chk_eq("R5 ID level 5", v, 16'h0055);
        rd(4'd9, v);       chk_eq("R5 ID level 2", v, 16'h0022);
        irq_i = '0;
        wr(RA_STATUS, 16'h007F);

        // R4 disabled level ignored
        wr(RA_ENABLE, 16'h0077);
        @(negedge clk); irq_i[3] = 1'b1;
        repeat (20) @(negedge clk);
        chk_eq("R4 no request for disabled level", bus_req_o, 0);
        rd(RA_STATUS, v);  chk_eq("R4 disabled level not flagged", v, 0);
        expect_ack(4, 8'h44, 0);
        wr(RA_ENABLE, 16'h007F);
        drain();
        rd(4'd11, v);      chk_eq("R5 ID level 4 after enable", v, 16'h0044);
        irq_i = '0;
        wr(RA_STATUS, 16'h0008);

        // R7 acknowledge ending in bus error
        expect_ack(6, 8'h66, 1);
        @(negedge clk); irq_i[5] = 1'b1;
        drain();
        rd(RA_STATUS, v);  chk_eq("R7 only fault bit set", v, 16'h0800);
        rd(4'd13, v);      chk_eq("R7 ID level 6 unchanged", v, 16'h0000);
        chk_eq("R9 fault routed to error output", host_err_o, 1);
        chk_eq("R9 fault not on normal output", host_int_o, 0);
        wr(RA_STATUS, 16'h0800);
        chk_eq("R9 error output drops", host_err_o, 0);

        // R8 event sources with routing
        wr(RA_ROUTE, 16'h0900);
        @(negedge clk); mbox_evt_i = 1'b1;
        @(negedge clk); mbox_evt_i = 1'b0;
        rd(RA_STATUS, v);  chk_eq("R8 mailbox bit 7", v, 16'h0080);
        chk_eq("R9 mailbox on normal output", host_int_o, 1);
        wr(RA_STATUS, 16'h0080);
        @(negedge clk); pwr_fail_i = 1'b1;
        @(negedge clk); pwr_fail_i = 1'b0;
        rd(RA_STATUS, v);  chk_eq("R8 power-fail bit 8", v, 16'h0100);
        chk_eq("R9 power-fail on error output", host_err_o, 1);
        chk_eq("R9 power-fail not on normal output", host_int_o, 0);
        wr(RA_ROUTE, 16'h0800);
        chk_eq("R9 reroute moves to normal output", host_int_o, 1);
        chk_eq("R9 reroute leaves error output", host_err_o, 0);
        wr(RA_STATUS, 16'h0100);
        @(negedge clk); bus_err_i = 1'b1; sys_fail_i = 1'b1;
        @(negedge clk); bus_err_i = 1'b0;
        rd(RA_STATUS, v);  chk_eq("R8 bus error and system-fail bits", v, 16'h0600);
        wr(RA_STATUS, 16'h0600);
        rd(RA_STATUS, v);  chk_eq("R8 held source wins over clear", v, 16'h0400);
        sys_fail_i = 1'b0;
        wr(RA_STATUS, 16'h0400);
        rd(RA_STATUS, v);  chk_eq("R8 cleared once source low", v, 16'h0000);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule